// File: doc/BRIEF.md
# Front-End Hit Packet Serializer

This block turns one triggered event of a 128-channel front-end chip into a fixed 192-bit frame and shifts it out on a single serial line. A strobe marks the frame's bits. The frame opens with three 16-bit header words. Each header word starts with a 4-bit marker nibble that a downstream deframer uses to find word boundaries. The header words carry the bunch counter, the event counter with four status flags, and the chip identifier. The 128-bit hit map follows, and a CRC16 over everything before it closes the frame.

A one-cycle start pulse launches a frame while the block is idle. At that edge every input field is copied into the internal shift state, so the inputs may change as soon as the start edge has passed. One bit leaves per clock, most significant first. At a 40 MHz clock the 192 bits fill a 4.8 µs valid window. A start that arrives while a frame is in flight has no effect.

Top module: `hit_pkt_serializer`

## Requirements
- R1: After a start edge that is accepted, `data_valid_o` is high for exactly 192 consecutive cycles, starting in the cycle that follows that edge, and then falls.
- R2: Frame bits 0..15, in send order, are the marker `1010` and then `bunch_cnt_i[11:0]` MSB first.
- R3: Frame bits 16..31 are the marker `1100`, then `event_cnt_i[7:0]` MSB first, then `flags_i[3:0]` MSB first.
- R4: Frame bits 32..47 are the marker `1110` and then `chip_id_i[11:0]` MSB first.
- R5: Frame bits 48..175 are `hits_i`, with channel 127 sent first and channel 0 sent last.
- R6: Frame bits 176..191 are a CRC16, sent MSB first. It uses polynomial 0x1021 with initial value 0xFFFF, takes no final XOR, and covers frame bits 0..175 in send order.
- R7: `busy_o` is high for the whole frame. A start pulse while busy leaves the frame in flight and its length unchanged.
- R8: The fields are captured at the start edge. Input changes during a frame do not alter the bits sent.
- R9: After reset, `data_valid_o`, `busy_o` and `serial_o` are low.
- R10: `serial_o` is low in every cycle in which `data_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame launch pulse, honoured only when idle |
| hits_i | input | 128 | Latched channel hit map |
| bunch_cnt_i | input | 12 | Bunch counter value |
| event_cnt_i | input | 8 | Event counter value |
| flags_i | input | 4 | Status flags |
| chip_id_i | input | 12 | Chip identifier |
| serial_o | output | 1 | Serial frame bit, MSB first |
| data_valid_o | output | 1 | High during the 192 frame bits |
| busy_o | output | 1 | High while a frame is in flight |

## Verification
A wrong bit counter shows up at once as a valid window that is not exactly 192 cycles long, or as marker nibbles at the wrong positions. Either is visible within the first frame. A corrupted capture register or CRC state does not show until the fields or the last 16 bits of that same frame. The bench compares each field, and the CRC it computes bytewise on its own, for every frame. A start pulse and input changes in mid-frame check that the captured copy cannot be disturbed.

// File: rtl/hit_pkt_pkg.sv
package hit_pkt_pkg;
  localparam int HIT_W  = 128;
  localparam int BC_W   = 12;
  localparam int EC_W   = 8;
  localparam int FLAG_W = 4;
  localparam int ID_W   = 12;
  localparam int TAG_W  = 4;
  localparam int CRC_W  = 16;
  localparam int WORD_W = 16;
  localparam int BODY_W = 3 * WORD_W + HIT_W;
  localparam int FRAME_W = BODY_W + CRC_W;

  localparam logic [TAG_W-1:0] TAG_BC = 4'b1010;
  localparam logic [TAG_W-1:0] TAG_EC = 4'b1100;
  localparam logic [TAG_W-1:0] TAG_ID = 4'b1110;

  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;
endpackage

// File: rtl/hit_pkt_ctrl.sv
module hit_pkt_ctrl #(
  parameter int FRAME_W = 192,
  parameter int BODY_W  = 176,
  localparam int CNT_W  = $clog2(FRAME_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             load_o,
  output logic             crc_phase_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CRC_BEG = CNT_W'(BODY_W);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o      = start_i & ~busy_q;
  assign busy_o      = busy_q;
  assign cnt_o       = cnt_q;
  assign crc_phase_o = busy_q & (cnt_q >= CRC_BEG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= LAST);
  p_frame_end_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == LAST) |=> !busy_q);
  p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/hit_pkt_shift.sv
module hit_pkt_shift #(
  parameter int W = 176
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic         msb_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign msb_o = sh_q[W-1];

  p_load_shift_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> sh_q[W-1] == $past(sh_q[W-2]));
endmodule

// File: rtl/hit_pkt_crc.sv
module hit_pkt_crc #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    POLY = 16'h1021,
  parameter logic [W-1:0]    INIT = 16'hFFFF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic upd_i,
  input  logic bit_i,
  input  logic emit_i,
  output logic msb_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb = crc_q[W-1] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (init_i)  crc_q <= INIT;
    else if (upd_i)   crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    else if (emit_i)  crc_q <= {crc_q[W-2:0], 1'b0};
  end

  assign msb_o = crc_q[W-1];

  p_upd_emit_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_i && emit_i));
endmodule

// File: rtl/hit_pkt_serializer.sv
module hit_pkt_serializer
  import hit_pkt_pkg::*;
#(
  parameter int HW = HIT_W,
  parameter int BW = BC_W,
  parameter int EW = EC_W,
  parameter int FW = FLAG_W,
  parameter int IW = ID_W,
  localparam int BODY  = 3 * TAG_W + BW + EW + FW + IW + HW,
  localparam int FRAME = BODY + CRC_W,
  localparam int CNT_W = $clog2(FRAME)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [HW-1:0] hits_i,
  input  logic [BW-1:0] bunch_cnt_i,
  input  logic [EW-1:0] event_cnt_i,
  input  logic [FW-1:0] flags_i,
  input  logic [IW-1:0] chip_id_i,
  output logic          serial_o,
  output logic          data_valid_o,
  output logic          busy_o
);
  logic             busy, load, crc_phase;
  logic [CNT_W-1:0] cnt;
  logic             body_bit, crc_bit;
  logic [BODY-1:0]  body;

  // channel 127 lands in the MSB side so it leaves first
  assign body = {TAG_BC, bunch_cnt_i, TAG_EC, event_cnt_i, flags_i,
                 TAG_ID, chip_id_i, hits_i};

  hit_pkt_ctrl #(.FRAME_W(FRAME), .BODY_W(BODY)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_o      (busy),
    .load_o      (load),
    .crc_phase_o (crc_phase),
    .cnt_o       (cnt)
  );

  hit_pkt_shift #(.W(BODY)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (busy & ~crc_phase),
    .data_i  (body),
    .msb_o   (body_bit)
  );

  hit_pkt_crc #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (load),
    .upd_i  (busy & ~crc_phase),
    .bit_i  (body_bit),
    .emit_i (crc_phase),
    .msb_o  (crc_bit)
  );

  assign serial_o     = busy & (crc_phase ? crc_bit : body_bit);
  assign data_valid_o = busy;
  assign busy_o       = busy;

  p_idle_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_o |-> !serial_o);
  p_bc_tag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cnt == CNT_W'(0)) |-> serial_o);
  p_ec_tag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cnt == CNT_W'(18)) |-> !serial_o);
  p_id_tag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cnt == CNT_W'(34)) |-> serial_o);
endmodule

// File: tb/test_hit_pkt_serializer.sv
module test_hit_pkt_serializer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] hits = '0;
  logic [11:0]  bc = '0;
  logic [7:0]   ec = '0;
  logic [3:0]   fl = '0;
  logic [11:0]  id = '0;
  logic         ser, vld, busy;
  int           checks = 0;
  int           fails = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  hit_pkt_serializer i_hit_pkt_serializer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hits_i(hits),
    .bunch_cnt_i(bc), .event_cnt_i(ec), .flags_i(fl), .chip_id_i(id),
    .serial_o(ser), .data_valid_o(vld), .busy_o(busy));

  task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input logic [175:0] b);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < 22; k++) begin
      c = c ^ {b[175-8*k -: 8], 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic send(input logic [11:0] b, input logic [7:0] e, input logic [3:0] f,
                      input logic [11:0] i, input logic [127:0] h, input bit disturb);
    logic [191:0] rx = '0;
    logic [175:0] body;
    int nvld = 0, nbusy = 0, bad_idle = 0;
    @(negedge clk);
    bc = b; ec = e; fl = f; id = i; hits = h; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 192; n++) begin
      if (vld) nvld++;
      if (busy) nbusy++;
      rx[191-n] = ser;
      if (disturb && n == 60) begin
        start = 1'b1; bc = ~b; ec = ~e; fl = ~f; id = ~i; hits = ~h;
      end
      if (disturb && n == 61) start = 1'b0;
      @(negedge clk);
    end
    if (ser !== 1'b0) bad_idle = 1;
    chk("R1 valid length", 192'(nvld), 192'd192);
    chk("R1 valid falls", 192'(vld), 192'd0);
    chk("R7 busy length", 192'(nbusy), 192'd192);
    chk("R10 idle serial", 192'(bad_idle), 192'd0);
    body = {4'b1010, b, 4'b1100, e, f, 4'b1110, i, h};
    chk("R2 word1", 192'(rx[191:176]), 192'({4'b1010, b}));
    chk("R3 word2", 192'(rx[175:160]), 192'({4'b1100, e, f}));
    chk("R4 word3", 192'(rx[159:144]), 192'({4'b1110, i}));
    chk("R5 hits", 192'(rx[143:16]), 192'(h));
    chk("R6 crc", 192'(rx[15:0]), 192'(crc_ref(body)));
    if (disturb) chk("R8 capture frame", rx, {body, crc_ref(body)});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R9 reset valid", 192'(vld), 192'd0);
    chk("R9 reset busy", 192'(busy), 192'd0);
    chk("R9 reset serial", 192'(ser), 192'd0);
    #10 rst_n = 1'b1;
    send(12'h000, 8'h00, 4'h0, 12'h000, '0, 1'b0);
    send(12'hFFF, 8'hFF, 4'hF, 12'hFFF, '1, 1'b0);
    for (int n = 0; n < 16; n++) begin
      logic [127:0] h = (128'h1 << (n * 8 + 3)) | (128'h1 << 127 - n);
      send(12'h001 << (n % 12), 8'(n * 17), 4'(n), ~(12'h001 << (n % 12)), h, 1'b0);
    end
    send(12'hA5C, 8'h3C, 4'h9, 12'h5A3, {4{32'hDEADBEEF}}, 1'b1);
    send(12'h123, 8'h81, 4'h6, 12'h987, {64'h0123456789ABCDEF, 64'hFEDCBA9876543210}, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule